// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is the serial-bus target in front of an 18-byte configuration register file. It watches an oversampled SMBus/I2C clock and data pair, recognises its own 7-bit address and drives the data line open-drain for acknowledges and read data. A command byte chooses the kind of transfer. With its top bit set, the low seven bits name a register offset and the transfer is an indexed byte or word access. With its top bit clear, the transfer is a counted block access that always begins at offset 0.

The register storage sits outside the block. Writes leave the block as a one-cycle strobe carrying an offset and a data byte. Reads use a combinational offset/data pair: the block presents an offset and captures the returned byte in the same cycle. Neither path has back-pressure. The serial bus cannot be paused, so the storage must accept every strobe and answer every read in the same cycle. For this reason the write path has no ready signal and the read path has no valid signal.

The target itself filters accesses. Offsets holding read-only content never produce a write strobe. Offsets beyond the last register are acknowledged, but writes to them are dropped and reads from them return zero.

Top module: `rfs_smbus_target`

## Requirements
- R1: Only an address byte whose upper seven bits equal the parameter `DEV_ADDR` (default 0x69) is acknowledged. Any other address is left unacknowledged, and the rest of that transfer produces no write strobe.
- R2: Every byte is shifted most significant bit first. The target acknowledges a byte by pulling SDA low during the ninth clock.
- R3: A command byte with bit 7 set loads bits 6:0 as the register offset. A data byte that follows produces exactly one write strobe at that offset.
- R4: In a word write, the first data byte goes to the offset and the second to the offset plus one.
- R5: A block write uses command 0x00, then a byte count, then data. Data bytes go to offsets 0, 1, 2 … in order. The count byte is never written. A STOP after any whole byte ends the transfer, and only the bytes already sent are written.
- R6: In a block write, data bytes beyond the announced count are not acknowledged and not written.
- R7: A command byte with bit 7 clear and any of bits 6:0 set is not acknowledged, and nothing is written in that transfer.
- R8: After a command, a repeated START and the address with the read bit, the target returns bytes from the selected offset upward. A master not-acknowledge makes it release SDA.
- R9: A block read returns the register count (18) first, then the bytes of offsets 0 to 17 in ascending order.
- R10: Writes to read-only offsets (default offsets 1 and 8, set by `RO_MASK`) are acknowledged but produce no write strobe.
- R11: Offsets 18 and above are acknowledged. Writes to them produce no strobe, and reads from them return 0x00 whatever `rd_data_i` carries.
- R12: A write strobe lasts one cycle and occurs only while SCL is high. The SDA pull-down output changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_off_o | output | 7 | Offset of the strobed write |
| wr_data_o | output | 8 | Data of the strobed write |
| rd_off_o | output | 7 | Offset whose content is requested |
| rd_data_i | input | 8 | Register content at `rd_off_o`, same cycle |

## Verification
The bound checker watches four properties on every cycle. It checks that a strobe never lands on a read-only or out-of-range offset, that each strobe is a single cycle inside an SCL-high phase, that the write offset moves only with a strobe, and that the SDA pull-down changes only while SCL is low. Everything else depends on the order of bytes across a whole transfer, so only the bench scenarios can show it. This covers address filtering, the two command modes, word pairing, the block count (both the returned count and the cut-off for excess data), early STOP, and the zero returned for reads above the register range.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  // offset field width is fixed by the command byte layout
  localparam int OFF_W = 7;

  typedef enum logic [2:0] {
    RL_IDLE,
    RL_ADDR,
    RL_CMD,
    RL_CNT,
    RL_WDAT,
    RL_TX,
    RL_SKIP
  } role_e;
endpackage

// File: rtl/rfs_line_sync.sv
module rfs_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw;
  logic [1:0] s_now;
  logic [1:0] s_last;

  assign raw = {scl_raw, sda_raw};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign s_now[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_last <= '1;
    else        s_last <= s_now;
  end

  assign scl_s     = s_now[1];
  assign sda_s     = s_now[0];
  assign scl_rise  = s_now[1] & ~s_last[1];
  assign scl_fall  = ~s_now[1] & s_last[1];
  assign start_det = s_now[1] & s_last[1] & s_last[0] & ~s_now[0];
  assign stop_det  = s_now[1] & s_last[1] & ~s_last[0] & s_now[0];
endmodule

// File: rtl/rfs_access_gate.sv
module rfs_access_gate #(
  parameter int                NUM_REGS = 18,
  parameter logic [NUM_REGS-1:0] RO_MASK = 18'h00102,
  parameter int                OFF_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [OFF_W-1:0] wr_ptr,
  input  logic [7:0]       wr_byte,
  input  logic [OFF_W-1:0] rd_ptr,
  input  logic [7:0]       rd_raw,
  output logic             wr_stb,
  output logic [OFF_W-1:0] wr_off,
  output logic [7:0]       wr_data,
  output logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_byte
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(NUM_REGS - 1);

  function automatic logic writable(input logic [OFF_W-1:0] o);
    logic ro;
    ro = 1'b0;
    for (int i = 0; i < NUM_REGS; i++)
      if (RO_MASK[i] && (o == OFF_W'(i))) ro = 1'b1;
    return (o <= LAST) && !ro;
  endfunction

  logic accept;
  assign accept = wr_req && writable(wr_ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_off  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= accept;
      if (accept) begin
        wr_off  <= wr_ptr;
        wr_data <= wr_byte;
      end
    end
  end

  assign rd_off  = rd_ptr;
  assign rd_byte = (rd_ptr <= LAST) ? rd_raw : 8'h00;
endmodule

// File: rtl/rfs_txn_ctrl.sv
module rfs_txn_ctrl
  import rfs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_byte,
  output logic [OFF_W-1:0] ptr,
  output logic             wr_req,
  output logic [OFF_W-1:0] wr_ptr,
  output logic [7:0]       wr_byte,
  output logic             sda_low
);
  localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);

  role_e      role, nxt_role, target;
  logic [2:0] bc;
  logic       in_ack, ack_on, ack_pend, mack;
  logic [7:0] sh, txsh, rem;
  logic       blk, cmd_ok, cnt_first;
  logic [7:0] rx_byte, tx_src;
  logic       rx_role;

  assign rx_byte = {sh[6:0], sda_s};
  assign tx_src  = (blk && cnt_first) ? CNT_BYTE : rd_byte;
  assign rx_role = (role == RL_ADDR) || (role == RL_CMD) ||
                   (role == RL_CNT)  || (role == RL_WDAT);
  assign target  = (role == RL_TX) ? (mack ? RL_TX : RL_SKIP) : nxt_role;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role <= RL_IDLE;  nxt_role <= RL_IDLE;
      bc <= '0;  in_ack <= 1'b0;  ack_on <= 1'b0;  ack_pend <= 1'b0;
      mack <= 1'b0;  sh <= '0;  txsh <= '0;  rem <= '0;
      blk <= 1'b0;  cmd_ok <= 1'b0;  cnt_first <= 1'b0;
      ptr <= '0;  wr_req <= 1'b0;  wr_ptr <= '0;  wr_byte <= '0;
      sda_low <= 1'b0;
    end else begin
      wr_req <= 1'b0;
      if (start_det) begin
        role <= RL_ADDR;  bc <= '0;  in_ack <= 1'b0;  ack_on <= 1'b0;
        sda_low <= 1'b0;
      end else if (stop_det) begin
        role <= RL_IDLE;  bc <= '0;  in_ack <= 1'b0;  ack_on <= 1'b0;
        sda_low <= 1'b0;  cmd_ok <= 1'b0;
      end else if (scl_rise && !in_ack && (rx_role || role == RL_TX)) begin
        bc <= bc + 3'd1;
        if (bc == 3'd7) begin
          in_ack <= 1'b1;
          ack_on <= 1'b0;
        end
        if (rx_role) begin
          sh <= rx_byte;
          if (bc == 3'd7) begin
            ack_pend <= 1'b1;
            unique case (role)
              RL_ADDR: begin
                if (rx_byte[7:1] != DEV_ADDR) begin
                  ack_pend <= 1'b0;
                  nxt_role <= RL_SKIP;
                end else if (rx_byte[0]) begin
                  nxt_role  <= RL_TX;
                  cnt_first <= blk;
                end else begin
                  nxt_role <= RL_CMD;
                  cmd_ok   <= 1'b0;
                end
              end
              RL_CMD: begin
                if (rx_byte[7]) begin
                  ptr <= rx_byte[6:0];  blk <= 1'b0;
                  cmd_ok <= 1'b1;  nxt_role <= RL_WDAT;
                end else if (rx_byte[6:0] == 7'd0) begin
                  ptr <= '0;  blk <= 1'b1;
                  cmd_ok <= 1'b1;  nxt_role <= RL_CNT;
                end else begin
                  ack_pend <= 1'b0;  cmd_ok <= 1'b0;
                  nxt_role <= RL_SKIP;
                end
              end
              RL_CNT: begin
                rem      <= rx_byte;
                nxt_role <= RL_WDAT;
              end
              default: begin
                if (!blk || rem != 8'd0) begin
                  wr_req  <= 1'b1;
                  wr_ptr  <= ptr;
                  wr_byte <= rx_byte;
                  ptr     <= ptr + 1'b1;
                  if (blk) rem <= rem - 8'd1;
                  nxt_role <= RL_WDAT;
                end else begin
                  ack_pend <= 1'b0;
                  nxt_role <= RL_SKIP;
                end
              end
            endcase
          end
        end
      end else if (scl_rise && in_ack && ack_on && role == RL_TX) begin
        mack <= !sda_s;
      end else if (scl_fall && in_ack) begin
        if (!ack_on) begin
          ack_on  <= 1'b1;
          sda_low <= (role != RL_TX) && ack_pend;
        end else begin
          in_ack <= 1'b0;
          ack_on <= 1'b0;
          bc     <= '0;
          role   <= target;
          if (target == RL_TX) begin
            txsh    <= tx_src;
            sda_low <= !tx_src[7];
            if (blk && cnt_first) cnt_first <= 1'b0;
            else                  ptr <= ptr + 1'b1;
          end else begin
            sda_low <= 1'b0;
          end
        end
      end else if (scl_fall && !in_ack && role == RL_TX && bc != 3'd0) begin
        txsh    <= {txsh[6:0], 1'b0};
        sda_low <= !txsh[6];
      end
    end
  end
endmodule

// File: rtl/rfs_smbus_target.sv
module rfs_smbus_target
  import rfs_pkg::*;
#(
  parameter logic [6:0]          DEV_ADDR    = 7'h69,
  parameter int                  NUM_REGS    = 18,
  parameter logic [NUM_REGS-1:0] RO_MASK     = 18'h00102,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic       wr_stb_o,
  output logic [6:0] wr_off_o,
  output logic [7:0] wr_data_o,
  output logic [6:0] rd_off_o,
  input  logic [7:0] rd_data_i
);
  logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [OFF_W-1:0] ptr, wr_ptr;
  logic             wr_req;
  logic [7:0]       wr_byte, rd_byte;

  rfs_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  rfs_txn_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .ptr(ptr), .wr_req(wr_req), .wr_ptr(wr_ptr),
    .wr_byte(wr_byte), .sda_low(sda_pull_o)
  );

  rfs_access_gate #(.NUM_REGS(NUM_REGS), .RO_MASK(RO_MASK), .OFF_W(OFF_W)) gate_i (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_ptr(wr_ptr),
    .wr_byte(wr_byte), .rd_ptr(ptr), .rd_raw(rd_data_i),
    .wr_stb(wr_stb_o), .wr_off(wr_off_o), .wr_data(wr_data_o),
    .rd_off(rd_off_o), .rd_byte(rd_byte)
  );
endmodule

// File: rtl/rfs_smbus_target_chk.sv
module rfs_smbus_target_chk #(
  parameter int                  NUM_REGS = 18,
  parameter logic [NUM_REGS-1:0] RO_MASK  = 18'h00102
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_pull_o,
  input logic       wr_stb_o,
  input logic [6:0] wr_off_o
);
  function automatic logic legal_off(input logic [6:0] o);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_REGS; i++)
      if (RO_MASK[i] && (o == 7'(i))) hit = 1'b1;
    return (int'(o) < NUM_REGS) && !hit;
  endfunction

  // R10 R11
  wr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> legal_off(wr_off_o));

  // R12
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  // R12
  wr_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> scl_i);

  // R12
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

  // R3
  wr_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_off_o) |-> wr_stb_o);
endmodule

bind rfs_smbus_target rfs_smbus_target_chk #(
  .NUM_REGS(NUM_REGS), .RO_MASK(RO_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .wr_stb_o(wr_stb_o), .wr_off_o(wr_off_o)
);

// File: tb/rfs_smbus_target_tb_top.sv
`timescale 1ns/1ps
module rfs_smbus_target_tb_top;
  localparam logic [6:0] ADDR = 7'h69;
  localparam int NREG = 18;
  localparam int Q = 10;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic sda_pull_o, wr_stb_o;
  logic [6:0] wr_off_o, rd_off_o;
  logic [7:0] wr_data_o, rd_data_i;

  logic [7:0] mem [0:NREG-1];
  logic [7:0] exp_mem [0:NREG-1];
  logic [14:0] sbq [$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign sda_line  = sda_m & ~sda_pull_o;
  assign rd_data_i = (int'(rd_off_o) < NREG) ? mem[rd_off_o] : 8'hA5;

  rfs_smbus_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .wr_stb_o(wr_stb_o), .wr_off_o(wr_off_o),
    .wr_data_o(wr_data_o), .rd_off_o(rd_off_o), .rd_data_i(rd_data_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected writes as strobes appear
  always @(negedge clk) begin
    if (rst_n && wr_stb_o) begin
      mem[wr_off_o] <= wr_data_o;
      if (sbq.size() == 0) begin
        chk(1'b0, "R10/R11 unexpected strobe", {wr_off_o, wr_data_o}, 0);
      end else begin
        logic [14:0] e;
        e = sbq.pop_front();
        chk({wr_off_o, wr_data_o} == e, "R3 write strobe", {wr_off_o, wr_data_o}, e);
      end
    end
  end

  task automatic push_wr(input int off, input logic [7:0] d);
    sbq.push_back({7'(off), d});
    exp_mem[off] = d;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic put_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(H/2);
    ack = !sda_line;
    tick(H/2); scl_m = 1'b0; tick(Q);
    chk(ack == exp_ack, tag, int'(ack), int'(exp_ack));
  endtask

  task automatic get_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl_m = 1'b1; tick(H/2);
      b = {b[6:0], sda_line};
      tick(H/2); scl_m = 1'b0; tick(Q);
    end
    sda_m = nack; tick(Q); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic read_chk(input logic [7:0] cmd, input int n, input int first, input string tag);
    logic [7:0] b;
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R1 addr ack");
    put_byte(cmd, 1'b1, "R3 cmd ack");
    bus_rstart();
    put_byte({ADDR, 1'b1}, 1'b1, "R8 read addr ack");
    for (int k = 0; k < n; k++) begin
      get_byte(k == n-1, b);
      if (first + k < NREG) chk(b == exp_mem[first+k], tag, b, exp_mem[first+k]);
      else                  chk(b == 8'h00, "R11 read beyond range", b, 0);
    end
    bus_stop();
    chk(sda_pull_o == 1'b0, "R8 SDA released after nack", sda_pull_o, 0);
  endtask

  task automatic sb_empty(input string tag);
    tick(4);
    chk(sbq.size() == 0, tag, sbq.size(), 0);
  endtask

  initial begin
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) begin
      mem[i] = 8'h40 + 8'(i);
      exp_mem[i] = 8'h40 + 8'(i);
    end
    tick(5);
    chk(sda_pull_o == 1'b0 && wr_stb_o == 1'b0, "R12 reset idle", {sda_pull_o, wr_stb_o}, 0);
    rst_n = 1'b1;
    tick(10);

    // R2 R3: single byte write, MSB first
    push_wr(5, 8'h5A);
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R2 addr ack");
    put_byte(8'h85, 1'b1, "R3 cmd ack");
    put_byte(8'h5A, 1'b1, "R2 data ack");
    bus_stop();
    sb_empty("R3 byte write done");
    read_chk(8'h85, 1, 5, "R8 byte read");

    // R4: word write and word read
    push_wr(9, 8'h11);
    push_wr(10, 8'h22);
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R4 addr ack");
    put_byte(8'h89, 1'b1, "R4 cmd ack");
    put_byte(8'h11, 1'b1, "R4 low ack");
    put_byte(8'h22, 1'b1, "R4 high ack");
    bus_stop();
    sb_empty("R4 word write done");
    read_chk(8'h89, 2, 9, "R4 word read");

    // R1: foreign address ignored
    bus_start();
    put_byte({7'h12, 1'b0}, 1'b0, "R1 foreign addr nack");
    put_byte(8'h85, 1'b0, "R1 foreign cmd nack");
    put_byte(8'hFF, 1'b0, "R1 foreign data nack");
    bus_stop();
    sb_empty("R1 no strobe");
    read_chk(8'h85, 1, 5, "R1 register untouched");

    // R10: read-only offsets
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R10 addr ack");
    put_byte(8'h81, 1'b1, "R10 cmd ack");
    put_byte(8'hC3, 1'b1, "R10 ro data ack");
    bus_stop();
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R10 addr ack");
    put_byte(8'h88, 1'b1, "R10 cmd ack");
    put_byte(8'h3C, 1'b1, "R10 ro data ack");
    bus_stop();
    sb_empty("R10 no strobe");
    read_chk(8'h81, 1, 1, "R10 ro byte 1 kept");
    read_chk(8'h88, 1, 8, "R10 ro byte 8 kept");

    // R11: beyond range
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R11 addr ack");
    put_byte(8'h94, 1'b1, "R11 cmd ack");
    put_byte(8'h77, 1'b1, "R11 data ack");
    bus_stop();
    sb_empty("R11 no strobe");
    read_chk(8'h94, 1, 20, "R11 read zero");

    // R5 R6: block write, count 4, then one extra byte
    push_wr(0, 8'hA0);
    exp_mem[1] = exp_mem[1];
    push_wr(2, 8'hA2);
    push_wr(3, 8'hA3);
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R5 addr ack");
    put_byte(8'h00, 1'b1, "R5 block cmd ack");
    put_byte(8'h04, 1'b1, "R5 count ack");
    put_byte(8'hA0, 1'b1, "R5 data0 ack");
    put_byte(8'hA1, 1'b1, "R5 data1 ack");
    put_byte(8'hA2, 1'b1, "R5 data2 ack");
    put_byte(8'hA3, 1'b1, "R5 data3 ack");
    put_byte(8'hEE, 1'b0, "R6 excess nack");
    bus_stop();
    sb_empty("R6 block write done");

    // R5: early stop
    push_wr(0, 8'hB0);
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R5 addr ack");
    put_byte(8'h00, 1'b1, "R5 block cmd ack");
    put_byte(8'h05, 1'b1, "R5 count ack");
    put_byte(8'hB0, 1'b1, "R5 data0 ack");
    put_byte(8'hB1, 1'b1, "R5 data1 ack");
    bus_stop();
    sb_empty("R5 early stop");

    // R7: malformed block command
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R7 addr ack");
    put_byte(8'h05, 1'b0, "R7 bad cmd nack");
    put_byte(8'h01, 1'b0, "R7 follow nack");
    bus_stop();
    sb_empty("R7 no strobe");

    // R9: block read
    bus_start();
    put_byte({ADDR, 1'b0}, 1'b1, "R9 addr ack");
    put_byte(8'h00, 1'b1, "R9 cmd ack");
    bus_rstart();
    put_byte({ADDR, 1'b1}, 1'b1, "R9 read addr ack");
    get_byte(1'b0, b);
    chk(b == 8'(NREG), "R9 count byte", b, NREG);
    for (int k = 0; k < NREG; k++) begin
      get_byte(k == NREG-1, b);
      chk(b == exp_mem[k], "R9 block data", b, exp_mem[k]);
    end
    bus_stop();
    chk(sda_pull_o == 1'b0, "R9 SDA released", sda_pull_o, 0);
    sb_empty("R9 final queue");

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule